// File: doc/BRIEF.md
# Sigma-Delta Converter Controller

This block is the digital half of a first-order sigma-delta analog-to-digital converter. The integrator and the comparator are off-chip. The block drives a one-bit feedback line into a resistor-capacitor integrator. It reads the comparator's one-bit decision back through a synchronizer, and on every clock it sets the feedback line to the inverse of the decision it sampled. The density of ones on the feedback line then follows the analog level on the selected input.

A conversion begins with a start pulse. The block latches the requested channel, which selects one of four inputs of the external analog multiplexer. For a fixed window it counts the clock cycles in which the feedback line was high. At the end of the window the count, clipped to the 12-bit range, goes into the result register. The done flag is then set and a one-cycle interrupt pulse is issued. The done flag remains set until the host reads the result or starts another conversion.

Top module: `sdadc_ctrl`

## Requirements
- R1: While reset is active, fb_o, busy_o, done_o and irq_o are 0, result_o is 0 and chan_sel_o is 0.
- R2: A start pulse clears done_o and begins a conversion. busy_o is high for exactly 4096 clock cycles after the start edge and then falls, and done_o rises on that same edge.
- R3: During a conversion, fb_o equals the inverse of cmp_i as sampled three rising edges earlier (two synchronizer flops plus the feedback register). While idle, fb_o is 0.
- R4: result_o is the unsigned number of cycles in the 4096-cycle window in which fb_o was high, clipped to 4095.
- R5: irq_o is a single-cycle pulse that is high in exactly the cycle in which done_o first reads 1 after a conversion.
- R6: done_o stays set until a rd_i pulse clears it, or until the next start clears it. If rd_i arrives on the same edge on which the conversion completes, done_o is still set.
- R7: chan_sel_o takes the 2-bit channel number on chan_i (code 0 to 3 selects input 0 to 3) at a start. Changes on chan_i at any other time have no effect on chan_sel_o.
- R8: result_o keeps the previous result throughout a new conversion and changes only on the edge that completes it.
- R9: A start issued during a conversion abandons it, clears the count and begins a full new 4096-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| rd_i | input | 1 | One-cycle result-read pulse, clears done |
| chan_i | input | 2 | Requested channel number |
| cmp_i | input | 1 | Asynchronous comparator decision |
| fb_o | output | 1 | Feedback bit to the external integrator |
| chan_sel_o | output | 2 | Latched channel for the analog multiplexer |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 12 | Last completed result |
| done_o | output | 1 | Result available |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The assertions check the following on every cycle: the three-edge relation between the comparator input and the feedback bit, the idle-low feedback bit, the alignment of the interrupt pulse with the rise of done, the clearing of done by a read, channel stability away from starts, and result stability away from completions. They also check that the running count never exceeds the number of elapsed window cycles. Other behaviours are visible only in the bench scenarios. These are the exact 4096-cycle window length, the exact counts for particular comparator histories, the clipping of 4096 ones to 4095, the precedence of completion over a simultaneous read, the clearing of done by a new start, and a restart in mid-window.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int tally_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sdadc_sync.sv
module sdadc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin : chk_params
      assert (STAGES >= 2 && STAGES <= 8)
         else $error("sdadc_sync: STAGES must lie in 2..8");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d_i};
   end

   assign q_o = shreg[STAGES-1];

endmodule

// File: rtl/sdadc_window.sv
module sdadc_window
   import sdadc_pkg::*;
#(
   parameter int WINDOW = 4096,
   localparam int CW    = cnt_width(WINDOW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          rd_i,
   output logic          busy_o,
   output logic          run_nxt_o,
   output logic          end_o,
   output logic [CW-1:0] cyc_o,
   output logic          done_o,
   output logic          irq_o
);

   initial begin : chk_params
      assert (WINDOW >= 2) else $error("sdadc_window: WINDOW must be at least 2");
   end

   localparam logic [CW-1:0] LAST_CYC = CW'(WINDOW - 1);

   phase_e        phase_q;
   logic [CW-1:0] cyc_q;
   logic          done_q;
   logic          irq_q;
   logic          last_cyc;

   assign last_cyc  = (phase_q == PH_RUN) && (cyc_q == LAST_CYC);
   assign end_o     = last_cyc && !start_i;
   assign run_nxt_o = start_i || ((phase_q == PH_RUN) && !last_cyc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cyc_q   <= '0;
      end else if (start_i) begin
         phase_q <= PH_RUN;
         cyc_q   <= '0;
      end else if (phase_q == PH_RUN) begin
         if (last_cyc) begin
            phase_q <= PH_IDLE;
            cyc_q   <= '0;
         end else begin
            cyc_q   <= cyc_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= end_o;
         if (start_i)    done_q <= 1'b0;
         else if (end_o) done_q <= 1'b1;
         else if (rd_i)  done_q <= 1'b0;
      end
   end

   assign busy_o = (phase_q == PH_RUN);
   assign cyc_o  = cyc_q;
   assign done_o = done_q;
   assign irq_o  = irq_q;

   a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !start_i && !end_o) |=> !done_o);

   a_r5_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> done_o);

endmodule

// File: rtl/sdadc_accum.sv
module sdadc_accum
   import sdadc_pkg::*;
#(
   parameter int WINDOW = 4096,
   parameter int RES_W  = 12,
   localparam int CW    = cnt_width(WINDOW),
   localparam int OW    = tally_width(WINDOW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             end_i,
   input  logic             bit_i,
   input  logic [CW-1:0]    cyc_i,
   output logic [RES_W-1:0] result_o
);

   initial begin : chk_params
      assert (RES_W >= 1 && RES_W <= 24)
         else $error("sdadc_accum: RES_W must lie in 1..24");
   end

   localparam int RMAX = (1 << RES_W) - 1;

   logic [OW-1:0]    ones_q;
   logic [OW-1:0]    tally;
   logic [RES_W-1:0] res_nxt;
   logic [RES_W-1:0] res_q;

   assign tally = ones_q + OW'(bit_i);

   generate
      if (WINDOW > RMAX) begin : g_clip
         assign res_nxt = (tally > OW'(RMAX)) ? RES_W'(RMAX) : tally[RES_W-1:0];
      end else begin : g_fit
         assign res_nxt = RES_W'(tally);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
         res_q  <= '0;
      end else if (clr_i) begin
         ones_q <= '0;
      end else if (en_i) begin
         ones_q <= tally;
         if (end_i) res_q <= res_nxt;
      end
   end

   assign result_o = res_q;

   a_r4_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (ones_q <= OW'(cyc_i)));

endmodule

// File: rtl/sdadc_ctrl.sv
module sdadc_ctrl
   import sdadc_pkg::*;
#(
   parameter int CH_W        = 2,
   parameter int RES_W       = 12,
   parameter int WINDOW      = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rd_i,
   input  logic [CH_W-1:0]  chan_i,
   input  logic             cmp_i,
   output logic             fb_o,
   output logic [CH_W-1:0]  chan_sel_o,
   output logic             busy_o,
   output logic [RES_W-1:0] result_o,
   output logic             done_o,
   output logic             irq_o
);

   localparam int CW        = cnt_width(WINDOW);
   localparam int LOOP_LAT  = SYNC_STAGES + 1;

   initial begin : chk_params
      assert (CH_W >= 1 && CH_W <= 8) else $error("sdadc_ctrl: CH_W must lie in 1..8");
   end

   logic          cmp_s;
   logic          run_nxt;
   logic          win_end;
   logic [CW-1:0] cyc;
   logic          fb_q;
   logic [CH_W-1:0] chan_q;

   sdadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   sdadc_window #(.WINDOW(WINDOW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .rd_i      (rd_i),
      .busy_o    (busy_o),
      .run_nxt_o (run_nxt),
      .end_o     (win_end),
      .cyc_o     (cyc),
      .done_o    (done_o),
      .irq_o     (irq_o)
   );

   sdadc_accum #(.WINDOW(WINDOW), .RES_W(RES_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_i),
      .en_i     (busy_o),
      .end_i    (win_end),
      .bit_i    (fb_q),
      .cyc_i    (cyc),
      .result_o (result_o)
   );

   // Feedback modulator: one register closing the loop through the off-chip integrator.
   always_ff @(posedge clk) begin
      if (!rst_n)       fb_q <= 1'b0;
      else if (run_nxt) fb_q <= !cmp_s;
      else              fb_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       chan_q <= '0;
      else if (start_i) chan_q <= chan_i;
   end

   assign fb_o       = fb_q;
   assign chan_sel_o = chan_q;

   // Edges since reset, saturating, so that history-based checks only look at valid samples.
   logic [3:0] warm_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 4'hF) warm_q <= warm_q + 4'd1;
   end

   a_r3_fb_tracks_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (int'(warm_q) >= LOOP_LAT)) |-> (fb_o == !$past(cmp_i, LOOP_LAT)));

   a_r3_fb_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !fb_o);

   a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> irq_o);

   a_r7_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start_i) |-> $stable(chan_sel_o));

   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done_o) |-> $stable(result_o));

endmodule

// File: tb/sim_sdadc_ctrl.sv
`timescale 1ns/1ps
module sim_sdadc_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 4096;
   localparam int NVEC       = 7;
   localparam int NEVER      = 5000;

   typedef struct packed {
      logic [1:0]  ch;
      int          n_low;
      int          pre;
      logic        rd_end;
      logic        keep;
      logic [11:0] res;
   } vec_t;

   // n_low: number of window cycles with fb high (comparator low), NEVER = low throughout.
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 3,     0,    1'b0, 1'b0, 12'd3},
      '{2'd1, NEVER, 0,    1'b1, 1'b0, 12'd4095},
      '{2'd2, 4096,  0,    1'b0, 1'b1, 12'd4095},
      '{2'd3, 4095,  0,    1'b0, 1'b0, 12'd4095},
      '{2'd1, 2048,  1000, 1'b0, 1'b0, 12'd2048},
      '{2'd2, 4094,  0,    1'b0, 1'b0, 12'd4094},
      '{2'd0, 100,   0,    1'b0, 1'b0, 12'd100}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic        rd_i;
   logic [1:0]  chan_i;
   logic        cmp_i;
   logic        fb_o;
   logic [1:0]  chan_sel_o;
   logic        busy_o;
   logic [11:0] result_o;
   logic        done_o;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   int prev_res = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdadc_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .rd_i       (rd_i),
      .chan_i     (chan_i),
      .cmp_i      (cmp_i),
      .fb_o       (fb_o),
      .chan_sel_o (chan_sel_o),
      .busy_o     (busy_o),
      .result_o   (result_o),
      .done_o     (done_o),
      .irq_o      (irq_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin : main
      rst_n = 1'b0; start_i = 1'b0; rd_i = 1'b0; chan_i = 2'd3; cmp_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 fb_o",       fb_o,       0);
      chk("R1 busy_o",     busy_o,     0);
      chk("R1 done_o",     done_o,     0);
      chk("R1 irq_o",      irq_o,      0);
      chk("R1 result_o",   result_o,   0);
      chk("R1 chan_sel_o", chan_sel_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         vec_t t;
         t = VECS[v];
         chan_i = t.ch;
         cmp_i  = 1'b0;
         repeat (4) @(negedge clk);
         if (t.pre > 0) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (t.pre - 1) @(negedge clk);
            chk("R9 busy before restart", busy_o, 1);
         end
         start_i = 1'b1;
         @(posedge clk);
         for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (k == 1) begin
               start_i = 1'b0;
               chk("R2 start clears done", done_o, 0);
               chk("R2 busy after start",  busy_o, 1);
               chk("R3 fb first cycle",    fb_o,   1);
            end
            if (k == 10)   chk("R8 result held", result_o, prev_res);
            if (k == 2000) chan_i = ~t.ch;
            if (k == t.n_low - 2) cmp_i = 1'b1;
            if ((k == t.n_low || k == t.n_low + 1) && k <= WIN)
               chk("R3 fb follows cmp", fb_o, (k - 1 < t.n_low) ? 1 : 0);
            if (k == WIN) begin
               chk("R2 busy last cycle", busy_o, 1);
               chk("R2 done last cycle", done_o, 0);
               if (t.rd_end) rd_i = 1'b1;
            end
            @(posedge clk);
         end
         @(negedge clk);
         rd_i = 1'b0;
         chk("R2 busy falls",   busy_o,     0);
         chk("R6 done set",     done_o,     1);
         chk("R5 irq pulse",    irq_o,      1);
         chk("R4 result",       result_o,   t.res);
         chk("R7 chan latched", chan_sel_o, t.ch);
         chk("R3 fb idle",      fb_o,       0);
         @(negedge clk);
         chk("R5 irq single",   irq_o,      0);
         chk("R6 done stays",   done_o,     1);
         prev_res = t.res;
         if (!t.keep) begin
            rd_i = 1'b1;
            @(negedge clk);
            rd_i = 1'b0;
            chk("R6 read clears done", done_o, 0);
            chk("R8 result after read", result_o, t.res);
         end
      end

      chan_i = 2'd2;
      repeat (5) @(negedge clk);
      chk("R7 chan idle ignored", chan_sel_o, 0);
      finish_run();
   end

endmodule